// File: doc/BRIEF.md
# Prescaled Period Timer with Postscaler

This block is a periodic event timer for a small peripheral cluster. A fixed divide-by-four stage turns the system clock into a count tick. A prescaler of 1, 4 or 16 divides that tick further. An 8-bit up-counter runs against a period register and wraps to zero each time it matches. Every wrap drives a postscaler whose ratio is any integer from 1 to 16. When the postscaler reaches its terminal count, it raises a sticky interrupt flag that stays high until software clears it.

Software reaches the block through a simple register port with write strobe, 2-bit address, write data and combinational read data. The port gives access to a packed control byte, the counter and the period register. A separate clear input drops the flag. Every write to the control or counter register restarts all three internal dividers. The delay from that write to the first flag is therefore exact: 4 × prescale × (period + 1) × postscale clock cycles.

Top module: `tmr_period_timer`

## Requirements
- R1: After reset the control register reads 0, the counter reads 0, the period register reads 8'hFF, and the flag is low.
- R2: Address 0 is the control register: bits [6:0] are stored and bit 7 reads 0. Address 1 is the counter and address 2 the period register. Address 3 reads 0 and ignores writes. Read data follows the address in the same cycle.
- R3: The count tick occurs once every 4 clock cycles. Control bits [1:0] pick the prescale: 2'b00 gives 1:1, 2'b01 gives 1:4, and 2'b10 or 2'b11 give 1:16.
- R4: The counter increments by one on each prescaled tick. When it equals the period register on a prescaled tick, it returns to 0 instead, so one period lasts period+1 prescaled ticks.
- R5: Control bits [6:3] hold the postscale ratio minus one, so every ratio from 1 to 16 is available. The flag is set when the number of period matches reaches the ratio. Starting from counter 0 right after a control write, the flag rises exactly 4 × prescale × (period+1) × postscale cycles after that write.
- R6: Control bit 2 is the run enable. While it is low, the counter and all dividers hold their values.
- R7: A write to the counter or to the control register restarts the tick divider, prescaler and postscaler from zero. A write to the period register leaves them running.
- R8: Once set, the flag stays set until a clear is applied. A clear in a cycle with no terminal event makes the flag low in the next cycle.
- R9: When a clear and a terminal event fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address (0 control, 1 counter, 2 period) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| flag_clr_i | input | 1 | Clears the sticky flag |
| flag_o | output | 1 | Sticky interrupt flag |
| match_o | output | 1 | One-cycle pulse when the counter wraps on a period match |

## Verification
A table of control bytes covers every prescale code and postscale ratios of 1, 3, 8, 10, 15 and 16. For each entry the bench checks that the flag is still low one cycle before the computed delay and high on it. A postscaler that decoded the field without the +1, or as a power of two, misses that edge by thousands of cycles, and a counter that wrapped at the period instead of after it is off by a whole tick. Directed tests write the counter or period mid-prescale: a design that failed to restart the prescaler on a counter write, or restarted it on a period write, moves the next increment away from the expected cycle. The clear-versus-event collision and the run-low hold are checked at the ports, where a clear-priority flag or a free-running counter shows up at once.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CNT  = 2'd1,
        ADDR_PER  = 2'd2,
        ADDR_RSV  = 2'd3
    } tmr_addr_e;

    // Packed control byte, bit 7 unused: {post_m1[6:3], run[2], pre_sel[1:0]}
    typedef struct packed {
        logic [3:0] post_m1;
        logic       run;
        logic [1:0] pre_sel;
    } tmr_ctrl_t;

    localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned PRE_MID  = 4,
    parameter int unsigned PRE_MAX  = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       run_i,
    input  logic       sync_clr_i,
    input  logic [1:0] sel_i,
    output logic       ptick_o
);
    localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam int unsigned PRE_W = (PRE_MAX > 1) ? $clog2(PRE_MAX) : 1;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PRE_W-1:0] pre;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] ratio_m1;
    logic base_tick;
    logic pre_end;

    always_comb begin
        case (sel_i)
            2'b00:   ratio_m1 = '0;
            2'b01:   ratio_m1 = PRE_W'(PRE_MID - 1);
            default: ratio_m1 = PRE_W'(PRE_MAX - 1);
        endcase
    end

    assign base_tick = (st_q.div == DIV_W'(TICK_DIV - 1));
    assign pre_end   = (st_q.pre == ratio_m1);
    assign ptick_o   = run_i && !sync_clr_i && base_tick && pre_end;

    always_comb begin
        st_d = st_q;
        if (sync_clr_i) begin
            st_d = '0;
        end else if (run_i) begin
            st_d.div = base_tick ? '0 : st_q.div + 1'b1;
            if (base_tick) begin
                st_d.pre = pre_end ? '0 : st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr_postscaler.sv
module tmr_postscaler #(
    parameter int unsigned POST_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sync_clr_i,
    input  logic              step_i,
    input  logic [POST_W-1:0] ratio_m1_i,
    output logic              term_o
);
    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } post_st_t;

    post_st_t st_d, st_q;

    assign term_o = step_i && (st_q.cnt == ratio_m1_i);

    always_comb begin
        st_d = st_q;
        if (sync_clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            st_d.cnt = term_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/tmr_period_timer.sv
module tmr_period_timer
    import tmr_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned TICK_DIV = 4,
    parameter int unsigned PRE_MID  = 4,
    parameter int unsigned PRE_MAX  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic [1:0]       bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    input  logic             flag_clr_i,
    output logic             flag_o,
    output logic             match_o
);
    localparam int unsigned POST_W = 4;

    typedef struct packed {
        tmr_ctrl_t        ctrl;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic             flag;
    } top_st_t;

    top_st_t st_d, st_q;

    logic wr_ctrl, wr_cnt, wr_per;
    logic sync_clr;
    logic run_w, ptick_w, term_w, match_w;
    logic [CNT_W-1:0] cnt_w, per_w;

    assign wr_ctrl  = bus_wr_i && (bus_addr_i == ADDR_CTRL);
    assign wr_cnt   = bus_wr_i && (bus_addr_i == ADDR_CNT);
    assign wr_per   = bus_wr_i && (bus_addr_i == ADDR_PER);
    assign sync_clr = wr_ctrl || wr_cnt;
    assign run_w    = st_q.ctrl.run;
    assign cnt_w    = st_q.cnt;
    assign per_w    = st_q.per;

    tmr_prescaler #(
        .TICK_DIV (TICK_DIV),
        .PRE_MID  (PRE_MID),
        .PRE_MAX  (PRE_MAX)
    ) u_pre (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_w),
        .sync_clr_i (sync_clr),
        .sel_i      (st_q.ctrl.pre_sel),
        .ptick_o    (ptick_w)
    );

    assign match_w = ptick_w && (st_q.cnt == st_q.per) && !wr_cnt;
    assign match_o = match_w;

    tmr_postscaler #(
        .POST_W (POST_W)
    ) u_post (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_clr_i (sync_clr),
        .step_i     (match_w),
        .ratio_m1_i (st_q.ctrl.post_m1),
        .term_o     (term_w)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = tmr_ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
        end
        if (wr_per) begin
            st_d.per = bus_wdata_i;
        end
        if (wr_cnt) begin
            st_d.cnt = bus_wdata_i;
        end else if (ptick_w) begin
            st_d.cnt = match_w ? '0 : st_q.cnt + 1'b1;
        end
        // a terminal event wins over a software clear
        if (term_w)          st_d.flag = 1'b1;
        else if (flag_clr_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q      <= '0;
            st_q.per  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_CTRL: bus_rdata_o = CNT_W'(st_q.ctrl);
            ADDR_CNT:  bus_rdata_o = st_q.cnt;
            ADDR_PER:  bus_rdata_o = st_q.per;
            default:   bus_rdata_o = '0;
        endcase
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/tmr_period_timer_chk.sv
module tmr_period_timer_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             wr_i,
    input logic [1:0]       addr_i,
    input logic             clr_i,
    input logic             run_i,
    input logic             ptick_i,
    input logic             term_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic [CNT_W-1:0] per_i,
    input logic             flag_i
);
    logic wr_cnt;
    assign wr_cnt = wr_i && (addr_i == 2'd1);

    assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ptick_i && (cnt_i == per_i) && !wr_cnt) |=> (cnt_i == '0));

    assert_flag_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flag_i) |-> $past(term_i));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !wr_i) |=> $stable(cnt_i));

    assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !clr_i) |=> flag_i);

    assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !term_i) |=> !flag_i);

    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_i |=> flag_i);

endmodule

bind tmr_period_timer tmr_period_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .clr_i   (flag_clr_i),
    .run_i   (run_w),
    .ptick_i (ptick_w),
    .term_i  (term_w),
    .cnt_i   (cnt_w),
    .per_i   (per_w),
    .flag_i  (flag_o)
);

// File: tb/tb_tmr_period_timer.sv
module tb_tmr_period_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       clr = 1'b0;
    logic       flag;
    logic       match;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tmr_period_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .flag_clr_i  (clr),
        .flag_o      (flag),
        .match_o     (match)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [7:0]  per;
        logic [31:0] cycles;
    } vec_t;

    // ctrl = {0, post_m1[3:0], run, pre_sel[1:0]}; cycles = 4*pre*(per+1)*post
    localparam vec_t VECS [6] = '{
        '{8'h04, 8'd0, 32'd4},
        '{8'h15, 8'd3, 32'd192},
        '{8'h3E, 8'd2, 32'd1536},
        '{8'h7F, 8'd1, 32'd2048},
        '{8'h74, 8'd0, 32'd60},
        '{8'h4D, 8'd7, 32'd1280}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic clr_pulse();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic prep(input logic [7:0] per);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, per);
        clr_pulse();
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_reg(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd_reg(2'd1, v); chk("R1 cnt", v, 8'h00);
        rd_reg(2'd2, v); chk("R1 per", v, 8'hFF);
        chk("R1 flag", flag, 1'b0);

        // R2 register map and readback
        wr_reg(2'd1, 8'hA5);
        rd_reg(2'd1, v); chk("R2 cnt readback", v, 8'hA5);
        wr_reg(2'd3, 8'h5A);
        rd_reg(2'd3, v); chk("R2 addr3 reads zero", v, 8'h00);
        rd_reg(2'd1, v); chk("R2 addr3 write ignored", v, 8'hA5);
        wr_reg(2'd0, 8'hFB);
        rd_reg(2'd0, v); chk("R2 ctrl bit7 reads zero", v, 8'h7B);

        // R3 R5 vector table: flag edge at the computed cycle
        foreach (VECS[i]) begin
            prep(VECS[i].per);
            wr_reg(2'd0, VECS[i].ctrl);
            repeat (VECS[i].cycles - 1) @(negedge clk);
            chk($sformatf("R5 vec%0d flag low before", i), flag, 1'b0);
            @(negedge clk);
            chk($sformatf("R3 R5 vec%0d flag on time", i), flag, 1'b1);
        end

        // R4 counter sequence with wrap, period 2, 1:1 prescale
        prep(8'd2);
        wr_reg(2'd0, 8'h7C);
        repeat (4) @(negedge clk); rd_reg(2'd1, v); chk("R4 cnt 1", v, 8'd1);
        repeat (4) @(negedge clk); rd_reg(2'd1, v); chk("R4 cnt 2", v, 8'd2);
        repeat (4) @(negedge clk); rd_reg(2'd1, v); chk("R4 wrap to 0", v, 8'd0);
        repeat (4) @(negedge clk); rd_reg(2'd1, v); chk("R4 cnt after wrap", v, 8'd1);

        // R6 run low holds counter
        wr_reg(2'd0, 8'h78);
        repeat (40) @(negedge clk);
        rd_reg(2'd1, v); chk("R6 hold while stopped", v, 8'd1);

        // R7 counter write restarts the prescaler (1:16)
        prep(8'hFF);
        wr_reg(2'd0, 8'h06);
        repeat (19) @(negedge clk);
        wr_reg(2'd1, 8'd5);
        repeat (63) @(negedge clk); rd_reg(2'd1, v); chk("R7 cnt write restart early", v, 8'd5);
        @(negedge clk);             rd_reg(2'd1, v); chk("R7 cnt write restart tick", v, 8'd6);

        // R7 period write leaves the prescaler running (1:4)
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd0, 8'h05);
        repeat (4) @(negedge clk);
        wr_reg(2'd2, 8'hFF);
        repeat (9) @(negedge clk); rd_reg(2'd1, v); chk("R7 per write before tick", v, 8'd0);
        @(negedge clk);            rd_reg(2'd1, v); chk("R7 per write no restart", v, 8'd1);

        // R8 R9 sticky flag, clear, collision (event every 4 cycles)
        prep(8'd0);
        wr_reg(2'd0, 8'h04);
        repeat (4) @(negedge clk);
        chk("R8 flag set", flag, 1'b1);
        @(negedge clk);
        chk("R8 flag sticky", flag, 1'b1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R8 clear drops flag", flag, 1'b0);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        chk("R9 set wins over clear", flag, 1'b1);

        finish_run();
    end

endmodule